// File: doc/BRIEF.md
# I2C Register-Access Master

This block is a bus master for a two-wire serial bus with open-drain clock and data lines. It runs one whole register transaction per command. The caller gives a 7-bit target address, a register index, a write byte and a direction. For a write, the block sets the target's register to the given byte. For a read, it first points the target at the register, then turns the bus around with a repeated START and fetches one byte. At the end it pulses `done_o`, and at that moment it reports the read byte and two error flags.

The block never drives either line high. Each line has one output enable, and asserting that enable pulls the line low. The line inputs pass through a two-flop synchronizer. A bit-level engine splits each SCL period into four quarter-phases. It counts the high phases only after SCL has been seen high, so a target can stretch the clock. During any bit it sends, the engine also checks for lost arbitration. A transaction sequencer above the engine steps through the bytes and the acknowledge bits.

Top module: `i2c_reg_master`

## Requirements
- R1: The block only pulls SCL and SDA low, by setting `scl_oe_o` or `sda_oe_o` to 1. Whenever `busy_o` is low, both enables are 0.
- R2: The first byte after a START is the address shifted left by one, with bit 0 set to 0 for write and 1 for read (address 0x27 for a write gives 0x4E). A write puts these bytes on the bus in this order: START, address byte with bit 0 = 0, register index, data byte, STOP.
- R3: A read puts these on the bus in this order: START, address byte with bit 0 = 0, register index, a repeated START with no STOP before it, address byte with bit 0 = 1, then eight bits received from the target. The master answers those eight bits with a high (NACK) bit, then sends STOP. The received byte, most significant bit first, appears on `rdata_o` when `done_o` is high.
- R4: While SCL is high, SDA changes only for START and STOP. A write therefore shows exactly one START and one STOP, and a read shows two STARTs and one STOP.
- R5: If the target leaves the acknowledge bit high after the address, register or data byte, the block stops sending bytes, issues a STOP, and ends with `err_nack_o` = 1 and `err_arb_o` = 0.
- R6: If the block releases SDA to send a 1 but samples SDA low in the middle of the SCL high phase, it releases both lines at once and sends no STOP. It then ends with `err_arb_o` = 1 and `err_nack_o` = 0, and no register write takes effect.
- R7: After releasing SCL, the block waits until SCL reads high before it times the high phase. A target that holds SCL low therefore lengthens the transaction, and no bits are lost.
- R8: `busy_o` goes high in the cycle after `cmd_valid_i` is accepted while idle, and goes low in the cycle in which `done_o` pulses. `done_o` is high for exactly one cycle. A command presented while `busy_o` is high is ignored and produces no transaction and no extra `done_o`.
- R9: With no stretching, successive SCL falling edges inside a byte are between `SCL_DIV` and `SCL_DIV`+4 system clocks apart.
- R10: `rdata_o`, `err_nack_o` and `err_arb_o` keep their values between transactions. The two error flags are never high together, and accepting a new command clears both of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe, taken only when idle |
| cmd_read_i | input | 1 | 1 = read transaction, 0 = write transaction |
| cmd_addr_i | input | 7 | Target address |
| cmd_reg_i | input | 8 | Register index |
| cmd_wdata_i | input | 8 | Byte to write |
| busy_o | output | 1 | High from command acceptance until done |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| rdata_o | output | 8 | Byte returned by the last read |
| err_nack_o | output | 1 | The target did not acknowledge |
| err_arb_o | output | 1 | Arbitration was lost |
| scl_i | input | 1 | Level on the SCL line |
| sda_i | input | 1 | Level on the SDA line |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |

## Verification
The hardest case to reach is lost arbitration. It needs a second driver to hold SDA low during an address bit in which this block sends a 1, and only while SCL is high. The bench arms a rival pull-down that engages on the first SCL fall after START. The address 0x27 starts with the bits 0 then 1, so the block loses on its second bit. The bench then checks that both lines were released and that the target's registers did not change. Clock stretching is produced by a target model that holds SCL low after each acknowledge for longer than the block's low phase.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BIT_CNT_W = $clog2(BYTE_W + 1);

  typedef enum logic [1:0] {BOP_START, BOP_STOP, BOP_TX, BOP_RX} bus_op_e;

  typedef enum logic [2:0] {
    STP_START, STP_ADDR_W, STP_REG, STP_DATA,
    STP_RSTART, STP_ADDR_R, STP_RDATA, STP_STOP
  } txn_step_e;

  typedef enum logic [1:0] {C_IDLE, C_ISSUE, C_WAIT} seq_ctrl_e;
endpackage

// File: rtl/i2c_in_sync.sv
module i2c_in_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] pipe_q;
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q <= '1;
        else         pipe_q <= d_i[g];
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q <= '1;
        else         pipe_q <= {pipe_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = pipe_q[STAGES-1];
  end
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2c_reg_pkg::*;
#(
  parameter int unsigned QTR = 5
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    op_valid_i,
  input  bus_op_e op_i,
  input  logic    tx_bit_i,
  input  logic    scl_s_i,
  input  logic    sda_s_i,
  output logic    op_done_o,
  output logic    rx_bit_o,
  output logic    arb_lost_o,
  output logic    scl_oe_o,
  output logic    sda_oe_o
);
  localparam int unsigned CW = $clog2(QTR) + 1;

  logic          act_q;
  logic [1:0]    ph_q;
  logic [CW-1:0] cnt_q;
  bus_op_e       op_q;
  logic          bit_q;
  logic          is_bit, wait_high, run, qtr_end;

  always_comb begin
    is_bit    = (op_q == BOP_TX) || (op_q == BOP_RX);
    // high phases start only once the line is seen high (stretching)
    wait_high = (ph_q == 2'd1 && !is_bit) || (ph_q == 2'd2 && is_bit);
    run       = act_q && !(wait_high && !scl_s_i);
    qtr_end   = run && (cnt_q == CW'(QTR - 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q      <= 1'b0;
      ph_q       <= '0;
      cnt_q      <= '0;
      op_q       <= BOP_STOP;
      bit_q      <= 1'b0;
      op_done_o  <= 1'b0;
      rx_bit_o   <= 1'b0;
      arb_lost_o <= 1'b0;
      scl_oe_o   <= 1'b0;
      sda_oe_o   <= 1'b0;
    end else begin
      op_done_o  <= 1'b0;
      arb_lost_o <= 1'b0;
      if (!act_q) begin
        if (op_valid_i) begin
          act_q <= 1'b1;
          ph_q  <= '0;
          cnt_q <= '0;
          op_q  <= op_i;
          bit_q <= tx_bit_i;
          case (op_i)
            BOP_START: sda_oe_o <= 1'b0;
            BOP_STOP:  sda_oe_o <= 1'b1;
            BOP_TX:    sda_oe_o <= ~tx_bit_i;
            default:   sda_oe_o <= 1'b0;
          endcase
        end
      end else if (run) begin
        if (!qtr_end) begin
          cnt_q <= cnt_q + 1'b1;
        end else begin
          cnt_q <= '0;
          ph_q  <= ph_q + 1'b1;
          case (ph_q)
            2'd0: if (!is_bit) scl_oe_o <= 1'b0;
            2'd1: begin
              if (is_bit)                 scl_oe_o <= 1'b0;
              else if (op_q == BOP_START) sda_oe_o <= 1'b1;
              else                        sda_oe_o <= 1'b0;
            end
            2'd2: begin
              rx_bit_o <= sda_s_i;
              if (op_q == BOP_TX && bit_q && !sda_s_i) begin
                scl_oe_o   <= 1'b0;
                sda_oe_o   <= 1'b0;
                act_q      <= 1'b0;
                op_done_o  <= 1'b1;
                arb_lost_o <= 1'b1;
              end else if (op_q == BOP_START) begin
                scl_oe_o <= 1'b1;
              end else if (op_q == BOP_STOP) begin
                act_q     <= 1'b0;
                op_done_o <= 1'b1;
              end
            end
            default: begin
              if (is_bit) scl_oe_o <= 1'b1;
              act_q     <= 1'b0;
              op_done_o <= 1'b1;
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/i2c_txn_seq.sv
module i2c_txn_seq
  import i2c_reg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic              cmd_read_i,
  input  logic [6:0]        cmd_addr_i,
  input  logic [BYTE_W-1:0] cmd_reg_i,
  input  logic [BYTE_W-1:0] cmd_wdata_i,
  input  logic              op_done_i,
  input  logic              rx_bit_i,
  input  logic              arb_lost_i,
  output logic              op_valid_o,
  output bus_op_e           op_o,
  output logic              tx_bit_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              err_nack_o,
  output logic              err_arb_o
);
  localparam logic [BIT_CNT_W-1:0] ACK_IDX = BIT_CNT_W'(BYTE_W);

  seq_ctrl_e            ctrl_q;
  txn_step_e            step_q;
  logic [BIT_CNT_W-1:0] bit_q;
  logic                 rd_q;
  logic [6:0]           addr_q;
  logic [BYTE_W-1:0]    reg_q, wdata_q, cur_byte;
  txn_step_e            next_byte_step;

  always_comb begin
    case (step_q)
      STP_ADDR_W: cur_byte = {addr_q, 1'b0};
      STP_ADDR_R: cur_byte = {addr_q, 1'b1};
      STP_REG:    cur_byte = reg_q;
      default:    cur_byte = wdata_q;
    endcase
    case (step_q)
      STP_ADDR_W: next_byte_step = STP_REG;
      STP_REG:    next_byte_step = rd_q ? STP_RSTART : STP_DATA;
      STP_ADDR_R: next_byte_step = STP_RDATA;
      default:    next_byte_step = STP_STOP;
    endcase
  end

  always_comb begin
    tx_bit_o = 1'b1;
    case (step_q)
      STP_START, STP_RSTART: op_o = BOP_START;
      STP_STOP:              op_o = BOP_STOP;
      STP_RDATA:             op_o = (bit_q == ACK_IDX) ? BOP_TX : BOP_RX;
      default: begin
        if (bit_q == ACK_IDX) op_o = BOP_RX;
        else begin
          op_o     = BOP_TX;
          tx_bit_o = cur_byte[3'd7 - bit_q[2:0]];
        end
      end
    endcase
  end

  assign op_valid_o = (ctrl_q == C_ISSUE);
  assign busy_o     = (ctrl_q != C_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= C_IDLE;
      step_q     <= STP_START;
      bit_q      <= '0;
      rd_q       <= 1'b0;
      addr_q     <= '0;
      reg_q      <= '0;
      wdata_q    <= '0;
      done_o     <= 1'b0;
      rdata_o    <= '0;
      err_nack_o <= 1'b0;
      err_arb_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (ctrl_q)
        C_IDLE: if (cmd_valid_i) begin
          rd_q       <= cmd_read_i;
          addr_q     <= cmd_addr_i;
          reg_q      <= cmd_reg_i;
          wdata_q    <= cmd_wdata_i;
          err_nack_o <= 1'b0;
          err_arb_o  <= 1'b0;
          step_q     <= STP_START;
          bit_q      <= '0;
          ctrl_q     <= C_ISSUE;
        end
        C_ISSUE: ctrl_q <= C_WAIT;
        default: if (op_done_i) begin
          if (arb_lost_i) begin
            err_arb_o <= 1'b1;
            ctrl_q    <= C_IDLE;
            done_o    <= 1'b1;
          end else begin
            ctrl_q <= C_ISSUE;
            case (step_q)
              STP_START:  begin step_q <= STP_ADDR_W; bit_q <= '0; end
              STP_RSTART: begin step_q <= STP_ADDR_R; bit_q <= '0; end
              STP_STOP: begin
                ctrl_q <= C_IDLE;
                done_o <= 1'b1;
              end
              STP_RDATA: begin
                if (bit_q != ACK_IDX) begin
                  rdata_o <= {rdata_o[BYTE_W-2:0], rx_bit_i};
                  bit_q   <= bit_q + 1'b1;
                end else begin
                  step_q <= STP_STOP;
                end
              end
              default: begin
                if (bit_q != ACK_IDX) begin
                  bit_q <= bit_q + 1'b1;
                end else if (rx_bit_i) begin
                  err_nack_o <= 1'b1;
                  step_q     <= STP_STOP;
                end else begin
                  step_q <= next_byte_step;
                  bit_q  <= '0;
                end
              end
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/i2c_reg_master.sv
module i2c_reg_master
  import i2c_reg_pkg::*;
#(
  parameter int unsigned SCL_DIV     = 20,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic       cmd_read_i,
  input  logic [6:0] cmd_addr_i,
  input  logic [7:0] cmd_reg_i,
  input  logic [7:0] cmd_wdata_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] rdata_o,
  output logic       err_nack_o,
  output logic       err_arb_o,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe_o,
  output logic       sda_oe_o
);
  localparam int unsigned QTR = (SCL_DIV / 4 < 3) ? 3 : SCL_DIV / 4;

  logic [1:0] bus_s;
  logic       op_valid, tx_bit, op_done, rx_bit, arb_lost;
  bus_op_e    op;

  i2c_in_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({scl_i, sda_i}),
    .q_o    (bus_s)
  );

  i2c_bit_engine #(.QTR(QTR)) u_bit (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_valid_i (op_valid),
    .op_i       (op),
    .tx_bit_i   (tx_bit),
    .scl_s_i    (bus_s[1]),
    .sda_s_i    (bus_s[0]),
    .op_done_o  (op_done),
    .rx_bit_o   (rx_bit),
    .arb_lost_o (arb_lost),
    .scl_oe_o   (scl_oe_o),
    .sda_oe_o   (sda_oe_o)
  );

  i2c_txn_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_read_i  (cmd_read_i),
    .cmd_addr_i  (cmd_addr_i),
    .cmd_reg_i   (cmd_reg_i),
    .cmd_wdata_i (cmd_wdata_i),
    .op_done_i   (op_done),
    .rx_bit_i    (rx_bit),
    .arb_lost_i  (arb_lost),
    .op_valid_o  (op_valid),
    .op_o        (op),
    .tx_bit_o    (tx_bit),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .rdata_o     (rdata_o),
    .err_nack_o  (err_nack_o),
    .err_arb_o   (err_arb_o)
  );
endmodule

// File: rtl/i2c_reg_master_chk.sv
module i2c_reg_master_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_valid_i,
  input logic       busy_o,
  input logic       done_o,
  input logic [7:0] rdata_o,
  input logic       err_nack_o,
  input logic       err_arb_o,
  input logic       scl_i,
  input logic       scl_oe_o,
  input logic       sda_oe_o
);
  assert_idle_released_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!scl_oe_o && !sda_oe_o));

  assert_arb_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_arb_o) |-> (!scl_oe_o && !sda_oe_o));

  // while the master has released SCL and it still reads low, keep waiting
  assert_stretch_wait_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !scl_oe_o && !scl_i) |=> (!scl_oe_o || !busy_o));

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_not_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_accept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(cmd_valid_i));

  assert_err_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(err_nack_o && err_arb_o));

  assert_result_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !done_o) |-> ($stable(rdata_o) && $stable(err_nack_o) && $stable(err_arb_o)));
endmodule

bind i2c_reg_master i2c_reg_master_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .rdata_o     (rdata_o),
  .err_nack_o  (err_nack_o),
  .err_arb_o   (err_arb_o),
  .scl_i       (scl_i),
  .scl_oe_o    (scl_oe_o),
  .sda_oe_o    (sda_oe_o)
);

// File: tb/sim_i2c_reg_master.sv
`timescale 1ns/1ps
module sim_i2c_reg_master;
  localparam int SCL_DIV = 20;
  localparam logic [6:0] TGT = 7'h27;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_read = 1'b0;
  logic [6:0] cmd_addr = '0;
  logic [7:0] cmd_reg = '0, cmd_wdata = '0;
  logic busy_o, done_o, err_nack_o, err_arb_o, scl_oe_o, sda_oe_o;
  logic [7:0] rdata_o;
  logic tgt_sda_pull = 1'b0, tgt_scl_pull = 1'b0, rival_pull = 1'b0;
  wire scl_w = !(scl_oe_o || tgt_scl_pull);
  wire sda_w = !(sda_oe_o || tgt_sda_pull || rival_pull);

  always #4 clk = ~clk;

  i2c_reg_master #(.SCL_DIV(SCL_DIV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_read_i(cmd_read),
    .cmd_addr_i(cmd_addr), .cmd_reg_i(cmd_reg), .cmd_wdata_i(cmd_wdata),
    .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o), .err_nack_o(err_nack_o),
    .err_arb_o(err_arb_o), .scl_i(scl_w), .sda_i(sda_w), .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o));

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // ---- behavioural target + bus monitor ----
  logic [7:0] mem [256];
  logic [7:0] byte_log [$];
  int starts = 0, stops = 0, cyc = 0, bitn = -1, byte_idx = 0;
  int stretch_len = 0, stretch_cnt = 0, last_fall = 0, per_min = 1000, per_max = 0;
  bit nack_data = 0, rival_arm = 0, rival_go = 0, in_frame = 0;
  bit tgt_sel = 0, tgt_rd = 0, rd_pending = 0;
  logic [7:0] sh = '0, ptr = '0, txb = '0;
  logic p_scl = 1'b1, p_sda = 1'b1;

  always @(negedge clk) begin
    logic s, d, ack;
    if (rst_n) begin
      s = scl_w; d = sda_w; cyc++;
      if (stretch_cnt > 0) begin
        stretch_cnt--;
        if (stretch_cnt == 0) tgt_scl_pull = 1'b0;
      end
      if (s && p_scl && p_sda && !d) begin
        starts++; bitn = -1; byte_idx = 0; tgt_rd = 0; rd_pending = 0;
        tgt_sda_pull = 1'b0; in_frame = 1;
        if (rival_arm) rival_go = 1;
      end else if (s && p_scl && !p_sda && d) begin
        stops++; in_frame = 0; tgt_sda_pull = 1'b0; tgt_rd = 0;
      end else if (s && !p_scl && in_frame) begin
        if (bitn >= 0 && bitn < 8 && !tgt_rd) sh = {sh[6:0], d};
      end else if (!s && p_scl && in_frame) begin
        if (rival_go) begin rival_pull = 1'b1; rival_go = 0; end
        bitn++;
        if (bitn >= 2 && bitn <= 8 && stretch_len == 0) begin
          if (cyc - last_fall < per_min) per_min = cyc - last_fall;
          if (cyc - last_fall > per_max) per_max = cyc - last_fall;
        end
        last_fall = cyc;
        if (bitn == 8) begin
          if (tgt_rd) tgt_sda_pull = 1'b0;
          else begin
            byte_log.push_back(sh);
            ack = 1'b0;
            if (byte_idx == 0) begin
              tgt_sel = (sh[7:1] == TGT);
              ack = tgt_sel;
              if (tgt_sel && sh[0]) rd_pending = 1;
            end else if (tgt_sel) begin
              if (byte_idx == 1) begin ptr = sh; ack = 1'b1; end
              else begin ack = !nack_data; if (ack) mem[ptr] = sh; end
            end
            tgt_sda_pull = ack;
            byte_idx++;
          end
        end else if (bitn == 9) begin
          bitn = 0; tgt_sda_pull = 1'b0;
          if (rd_pending) begin
            rd_pending = 0; tgt_rd = 1; txb = mem[ptr]; tgt_sda_pull = !txb[7];
          end
          if (stretch_len > 0) begin tgt_scl_pull = 1'b1; stretch_cnt = stretch_len; end
        end else if (tgt_rd && bitn >= 1 && bitn < 8) begin
          tgt_sda_pull = !txb[7-bitn];
        end
      end
      p_scl = s; p_sda = d;
    end
  end

  // ---- cycle-by-cycle reference: busy, done results, released lines ----
  int exp_rd_q[$], exp_nk_q[$], exp_ab_q[$], is_rd_q[$];
  bit model_busy = 0;
  int n_done = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_o) begin
        model_busy = 0;
        n_done++;
        chk(!scl_oe_o && !sda_oe_o, "R1 lines released at done", {scl_oe_o, sda_oe_o}, 0);
        if (exp_nk_q.size() == 0) chk(0, "R8 unexpected done", 1, 0);
        else begin
          int er, en, ea, ir;
          er = exp_rd_q.pop_front(); en = exp_nk_q.pop_front();
          ea = exp_ab_q.pop_front(); ir = is_rd_q.pop_front();
          chk(err_nack_o == en, "R5 err_nack at done", err_nack_o, en);
          chk(err_arb_o == ea, "R6 err_arb at done", err_arb_o, ea);
          if (ir != 0) chk(rdata_o == er, "R3 read data", rdata_o, er);
        end
      end else if (cmd_valid && !model_busy) model_busy = 1;
      chk(busy_o == model_busy, "R8 busy per cycle", busy_o, model_busy);
    end
  end

  task automatic run_cmd(input bit rd, input logic [6:0] a, input logic [7:0] r,
                         input logic [7:0] w, input int erd, input int enk,
                         input int eab, output int dur);
    int nd;
    while (busy_o) @(negedge clk);
    exp_rd_q.push_back(erd); exp_nk_q.push_back(enk);
    exp_ab_q.push_back(eab); is_rd_q.push_back(rd);
    nd = n_done;
    @(negedge clk); #1;
    cmd_valid = 1; cmd_read = rd; cmd_addr = a; cmd_reg = r; cmd_wdata = w;
    @(negedge clk); #1;
    cmd_valid = 0;
    dur = 0;
    while (n_done == nd) begin @(negedge clk); dur++; end
    repeat (4) @(negedge clk);
  endtask

  bit finished = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int d_plain, d_str, s0, p0, nd;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (5) @(negedge clk);
    chk(!busy_o && !done_o && !scl_oe_o && !sda_oe_o && !err_nack_o && !err_arb_o,
        "R1 R8 reset state", {busy_o, done_o, scl_oe_o, sda_oe_o}, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // R2 R4 R9: plain write
    byte_log.delete(); s0 = starts; p0 = stops;
    run_cmd(0, TGT, 8'h03, 8'hAA, 0, 0, 0, d_plain);
    chk(mem[3] == 8'hAA, "R2 write landed", mem[3], 8'hAA);
    chk(byte_log.size() == 3, "R2 write byte count", byte_log.size(), 3);
    if (byte_log.size() == 3) begin
      chk(byte_log[0] == 8'h4E, "R2 address byte", byte_log[0], 8'h4E);
      chk(byte_log[1] == 8'h03, "R2 register byte", byte_log[1], 8'h03);
      chk(byte_log[2] == 8'hAA, "R2 data byte", byte_log[2], 8'hAA);
    end
    chk(starts - s0 == 1 && stops - p0 == 1, "R4 write start/stop", (starts - s0) * 16 + stops - p0, 17);
    chk(per_min >= SCL_DIV && per_max <= SCL_DIV + 4, "R9 SCL bit period", per_min * 256 + per_max, SCL_DIV);

    // R3 R4: read with repeated start
    byte_log.delete(); s0 = starts; p0 = stops;
    run_cmd(1, TGT, 8'h03, 8'h00, 8'hAA, 0, 0, nd);
    chk(starts - s0 == 2 && stops - p0 == 1, "R3 R4 read start/stop", (starts - s0) * 16 + stops - p0, 33);
    chk(byte_log.size() == 3 && byte_log[2] == 8'h4F, "R3 read address byte",
        byte_log.size() == 3 ? byte_log[2] : 0, 8'h4F);
    mem[8'h42] = 8'h81;
    run_cmd(1, TGT, 8'h42, 8'h00, 8'h81, 0, 0, nd);
    chk(rdata_o == 8'h81, "R10 rdata held after done", rdata_o, 8'h81);

    // R7: stretching
    stretch_len = 40;
    run_cmd(0, TGT, 8'h05, 8'h5C, 0, 0, 0, d_str);
    chk(mem[5] == 8'h5C, "R7 stretched write", mem[5], 8'h5C);
    chk(d_str > d_plain + 40, "R7 stretch lengthens", d_str, d_plain + 40);
    run_cmd(1, TGT, 8'h05, 8'h00, 8'h5C, 0, 0, nd);
    stretch_len = 0;

    // R5: missing target, then NACK on data
    byte_log.delete(); p0 = stops;
    run_cmd(0, 7'h11, 8'h06, 8'h33, 0, 1, 0, nd);
    chk(byte_log.size() == 1, "R5 abort after address", byte_log.size(), 1);
    chk(stops - p0 == 1, "R5 STOP after NACK", stops - p0, 1);
    chk(mem[6] == 8'h00, "R5 nothing written", mem[6], 0);
    repeat (30) @(negedge clk);
    chk(err_nack_o == 1'b1, "R10 err_nack held", err_nack_o, 1);
    nack_data = 1;
    run_cmd(0, TGT, 8'h09, 8'h77, 0, 1, 0, nd);
    nack_data = 0;
    chk(mem[9] == 8'h00, "R5 data NACK no write", mem[9], 0);

    // R6: arbitration loss on second address bit
    rival_arm = 1;
    run_cmd(0, TGT, 8'h0A, 8'h55, 0, 0, 1, nd);
    rival_arm = 0;
    chk(!scl_oe_o && !sda_oe_o, "R6 lines released", {scl_oe_o, sda_oe_o}, 0);
    @(negedge clk); rival_pull = 1'b0;
    repeat (10) @(negedge clk);
    chk(mem[10] == 8'h00, "R6 no write after loss", mem[10], 0);
    run_cmd(0, TGT, 8'h0A, 8'h66, 0, 0, 0, nd);
    chk(mem[10] == 8'h66 && !err_arb_o, "R10 flags cleared, bus usable", mem[10], 8'h66);

    // R8: command while busy is ignored
    nd = n_done;
    exp_rd_q.push_back(0); exp_nk_q.push_back(0); exp_ab_q.push_back(0); is_rd_q.push_back(0);
    @(negedge clk); #1;
    cmd_valid = 1; cmd_read = 0; cmd_addr = TGT; cmd_reg = 8'h07; cmd_wdata = 8'h11;
    @(negedge clk); #1; cmd_valid = 0;
    repeat (50) @(negedge clk); #1;
    cmd_valid = 1; cmd_reg = 8'h08; cmd_wdata = 8'h22;
    @(negedge clk); #1; cmd_valid = 0;
    while (n_done == nd) @(negedge clk);
    repeat (2000) @(negedge clk);
    chk(n_done - nd == 1, "R8 one done only", n_done - nd, 1);
    chk(mem[7] == 8'h11, "R8 first command done", mem[7], 8'h11);
    chk(mem[8] == 8'h00, "R8 busy command ignored", mem[8], 0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule